// File: doc/BRIEF.md
# SPI NAND Page Operation Sequencer

This block turns one host request into the complete sequence of serial-flash operations that a NAND page read, page program, block erase or configuration write needs. It sits above a phase engine that shifts single operations on the wire (opcode, address bytes, dummy bytes, optional data). The sequencer never touches payload data. It selects each operation's descriptor, presents it to the engine, waits for the engine's completion, and decides what comes next.

Reads, programs and erases all end by polling the device status byte until its busy bit clears. A bounded number of polls guards against a device that never finishes. The sequencer then decodes the status byte into a single result code. For a read, the on-die ECC verdict is captured when polling ends, before the cache is read out. The read-out always runs, even when that verdict is uncorrectable.

Top module: `nand_page_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `pe_req_o` are 0 and `result_o` is 0.
- R2: A read command (`cmd_type_i`=0) begins with opcode 0x13, `pe_addr_o` = row, 3 address bytes, no dummy bytes, direction none (0), length 0.
- R3: Every status poll is opcode 0x0F, address 0x0000C0 with 1 address byte, direction inbound (1), length 1. Polls repeat while bit 0 of the returned byte is 1.
- R4: If `POLL_MAX` consecutive polls all return busy, the command ends with result 5 (timeout), and no further operation is issued.
- R5: After a read's polling clears, one cache read-out follows: opcode 0x03, or 0x0B when `cmd_fast_i` was 1; `pe_addr_o` = column in bits 15:0; 2 address bytes; `CACHE_DUMMY` dummy bytes; inbound; length = `cmd_len_i`.
- R6: The read result comes from status bits 5:4, latched on the poll that clears busy: 0 gives result 0, 1 gives result 1, and 2 or 3 give result 2. Bits 2 and 3 have no effect on a read.
- R7: A program command (`cmd_type_i`=1) issues these operations in order, then polls:
  - write enable 0x06, with no address and no data;
  - program load, opcode 0x02 (or 0x84 when `cmd_keep_i`=1), with the column, 2 address bytes, outbound (2) and length `cmd_len_i`;
  - program execute 0x10, with the row and 3 address bytes.
- R8: A finished program reports 3 when status bit 3 is set, and 0 otherwise. Bit 2 is ignored.
- R9: An erase command (`cmd_type_i`=2) issues 0x06 and then 0xD8 with the row and 3 address bytes, then polls. It reports 4 when status bit 2 is set and 0 otherwise. Bit 3 is ignored.
- R10: A configuration command (`cmd_type_i`=3) issues exactly one operation and then reports result 0 without polling. That operation is opcode 0x1F, address 0x0000B0, 1 address byte, outbound, length 1, with `pe_wdata_o` bit 4 = `cmd_cfg_i[1]`, bit 0 = `cmd_cfg_i[0]` and all other bits 0. `pe_wdata_o` is 0 for every other operation.
- R11: Command handshake and result timing:
  - `busy_o` rises the cycle after a command is accepted.
  - `done_o` is a one-cycle pulse with the result on `result_o`, during which `pe_req_o` is low; `busy_o` falls after it.
  - `result_o` holds until the next completion.
  - `cmd_valid_i` is ignored while busy.
- R12: Engine handshake:
  - `pe_req_o` and the descriptor stay stable from the start of an operation until the cycle in which `pe_done_i` is 1.
  - Each such cycle completes one operation.
  - A request still high after a completion cycle is the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, accepted when idle |
| cmd_type_i | input | 2 | 0 read, 1 program, 2 erase, 3 configuration |
| cmd_row_i | input | 24 | Page or block row address |
| cmd_col_i | input | 16 | Column (byte offset in cache) |
| cmd_len_i | input | LEN_W | Data byte count for read-out or load |
| cmd_fast_i | input | 1 | Use fast cache read opcode |
| cmd_keep_i | input | 1 | Program load keeps the other cache bytes |
| cmd_cfg_i | input | 2 | {ECC enable, quad enable} for configuration |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 3 | 0 ok, 1 corrected, 2 uncorrectable, 3 program fail, 4 erase fail, 5 timeout |
| pe_req_o | output | 1 | Operation request to the phase engine |
| pe_opcode_o | output | 8 | Operation opcode |
| pe_addr_o | output | 24 | Address, right-aligned |
| pe_addr_bytes_o | output | 2 | Number of address bytes |
| pe_dummy_bytes_o | output | 2 | Number of dummy bytes |
| pe_dir_o | output | 2 | Data direction: 0 none, 1 inbound, 2 outbound |
| pe_len_o | output | LEN_W | Data byte count |
| pe_wdata_o | output | 8 | Single outbound byte for feature writes |
| pe_done_i | input | 1 | Operation complete |
| pe_rdata_i | input | 8 | Last inbound byte (status value on polls) |

## Verification
The bench sweeps every ECC field value against both read opcodes and several busy durations. This separates the ECC mapping, the choice of opcode and the poll loop. Programs and erases run across all four combinations of the two fail bits, so the bench can tell whether each command type watches its own flag and ignores the other. Busy counts of exactly `POLL_MAX`-1 and `POLL_MAX` land on either side of the timeout edge. Every configuration bit pair is written once. A command pulsed in mid-sequence must leave the operation log unchanged.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {CMD_READ = 2'd0, CMD_PROG = 2'd1, CMD_ERASE = 2'd2, CMD_CFG = 2'd3} cmd_e;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_ECC_FIX    = 3'd1,
    RES_ECC_BAD    = 3'd2,
    RES_PROG_FAIL  = 3'd3,
    RES_ERASE_FAIL = 3'd4,
    RES_TIMEOUT    = 3'd5
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_PLOAD, S_PEXEC, S_ERASE, S_PREAD, S_POLL, S_CREAD, S_CFG, S_DONE
  } step_e;

  typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_IN = 2'd1, DIR_OUT = 2'd2} dir_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [23:0] addr;
    logic [1:0]  nab;
    logic [1:0]  ndum;
    dir_e        dir;
  } op_desc_t;

  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_PAGE_RD   = 8'h13;
  localparam logic [7:0] OP_CACHE_RD  = 8'h03;
  localparam logic [7:0] OP_CACHE_RDF = 8'h0B;
  localparam logic [7:0] OP_LOAD_RST  = 8'h02;
  localparam logic [7:0] OP_LOAD_KEEP = 8'h84;
  localparam logic [7:0] OP_EXEC      = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'hD8;
  localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
  localparam logic [7:0] OP_SET_FEAT  = 8'h1F;
  localparam logic [7:0] FEAT_STATUS  = 8'hC0;
  localparam logic [7:0] FEAT_CONFIG  = 8'hB0;

endpackage

// File: rtl/nand_op_rom.sv
module nand_op_rom
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int CACHE_DUMMY = 1
) (
  input  step_e            step_i,
  input  logic [23:0]      row_i,
  input  logic [15:0]      col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fast_i,
  input  logic             keep_i,
  input  logic [1:0]       cfg_i,
  output op_desc_t         desc_o,
  output logic [LEN_W-1:0] len_o,
  output logic [7:0]       wdata_o
);
  localparam logic [1:0] DUM = 2'(CACHE_DUMMY);

  always_comb begin
    desc_o  = '0;
    len_o   = '0;
    wdata_o = '0;
    unique case (step_i)
      S_WREN: desc_o.opcode = OP_WREN;
      S_PREAD: begin
        desc_o.opcode = OP_PAGE_RD;
        desc_o.addr   = row_i;
        desc_o.nab    = 2'd3;
      end
      S_POLL: begin
        desc_o.opcode = OP_GET_FEAT;
        desc_o.addr   = {16'h0, FEAT_STATUS};
        desc_o.nab    = 2'd1;
        desc_o.dir    = DIR_IN;
        len_o         = LEN_W'(1);
      end
      S_CREAD: begin
        desc_o.opcode = fast_i ? OP_CACHE_RDF : OP_CACHE_RD;
        desc_o.addr   = {8'h0, col_i};
        desc_o.nab    = 2'd2;
        desc_o.ndum   = DUM;
        desc_o.dir    = DIR_IN;
        len_o         = len_i;
      end
      S_PLOAD: begin
        desc_o.opcode = keep_i ? OP_LOAD_KEEP : OP_LOAD_RST;
        desc_o.addr   = {8'h0, col_i};
        desc_o.nab    = 2'd2;
        desc_o.dir    = DIR_OUT;
        len_o         = len_i;
      end
      S_PEXEC: begin
        desc_o.opcode = OP_EXEC;
        desc_o.addr   = row_i;
        desc_o.nab    = 2'd3;
      end
      S_ERASE: begin
        desc_o.opcode = OP_ERASE;
        desc_o.addr   = row_i;
        desc_o.nab    = 2'd3;
      end
      S_CFG: begin
        desc_o.opcode = OP_SET_FEAT;
        desc_o.addr   = {16'h0, FEAT_CONFIG};
        desc_o.nab    = 2'd1;
        desc_o.dir    = DIR_OUT;
        len_o         = LEN_W'(1);
        wdata_o       = {3'b000, cfg_i[1], 3'b000, cfg_i[0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_poll_ctr.sv
module nand_poll_ctr #(
  parameter int POLL_MAX = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int CW = $clog2(POLL_MAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // true while the poll in flight is the last one allowed
  assign last_o = (cnt_q == CW'(POLL_MAX - 1));
endmodule

// File: rtl/nand_status_eval.sv
module nand_status_eval
  import nand_seq_pkg::*;
#(
  parameter bit ECC_RSVD_BAD = 1'b1
) (
  input  cmd_e       kind_i,
  input  logic [7:0] status_i,
  output logic       busy_o,
  output res_e       res_o
);
  res_e rsvd_res;

  generate
    if (ECC_RSVD_BAD) begin : g_rsvd_bad
      assign rsvd_res = RES_ECC_BAD;
    end else begin : g_rsvd_fix
      assign rsvd_res = RES_ECC_FIX;
    end
  endgenerate

  logic unused_rsvd;
  assign unused_rsvd = ^{status_i[7:6], status_i[1]};
  assign busy_o = status_i[0];

  always_comb begin
    res_o = RES_OK;
    unique case (kind_i)
      CMD_READ: begin
        unique case (status_i[5:4])
          2'd0: res_o = RES_OK;
          2'd1: res_o = RES_ECC_FIX;
          2'd2: res_o = RES_ECC_BAD;
          default: res_o = rsvd_res;
        endcase
      end
      CMD_PROG:  res_o = status_i[3] ? RES_PROG_FAIL : RES_OK;
      CMD_ERASE: res_o = status_i[2] ? RES_ERASE_FAIL : RES_OK;
      default:   res_o = RES_OK;
    endcase
  end
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int POLL_MAX    = 16,
  parameter int CACHE_DUMMY = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_type_i,
  input  logic [23:0]      cmd_row_i,
  input  logic [15:0]      cmd_col_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_fast_i,
  input  logic             cmd_keep_i,
  input  logic [1:0]       cmd_cfg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       result_o,
  output logic             pe_req_o,
  output logic [7:0]       pe_opcode_o,
  output logic [23:0]      pe_addr_o,
  output logic [1:0]       pe_addr_bytes_o,
  output logic [1:0]       pe_dummy_bytes_o,
  output logic [1:0]       pe_dir_o,
  output logic [LEN_W-1:0] pe_len_o,
  output logic [7:0]       pe_wdata_o,
  input  logic             pe_done_i,
  input  logic [7:0]       pe_rdata_i
);
  step_e            state_q, state_d;
  cmd_e             kind_q;
  logic [23:0]      row_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q;
  logic             fast_q, keep_q;
  logic [1:0]       cfg_q;
  res_e             result_q, result_d, ecc_q, ecc_d;
  op_desc_t         desc;
  logic             st_busy, poll_last, accept;
  res_e             st_res;

  assign accept = (state_q == S_IDLE) && cmd_valid_i;

  nand_op_rom #(.LEN_W(LEN_W), .CACHE_DUMMY(CACHE_DUMMY)) u_rom (
    .step_i (state_q),
    .row_i  (row_q),
    .col_i  (col_q),
    .len_i  (len_q),
    .fast_i (fast_q),
    .keep_i (keep_q),
    .cfg_i  (cfg_q),
    .desc_o (desc),
    .len_o  (pe_len_o),
    .wdata_o(pe_wdata_o)
  );

  nand_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .tick_i (pe_done_i && (state_q == S_POLL)),
    .last_o (poll_last)
  );

  nand_status_eval u_eval (
    .kind_i  (kind_q),
    .status_i(pe_rdata_i),
    .busy_o  (st_busy),
    .res_o   (st_res)
  );

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    ecc_d    = ecc_q;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid_i) begin
          unique case (cmd_e'(cmd_type_i))
            CMD_READ: state_d = S_PREAD;
            CMD_CFG:  state_d = S_CFG;
            default:  state_d = S_WREN;
          endcase
        end
      end
      S_DONE: state_d = S_IDLE;
      default: begin
        if (pe_done_i) begin
          unique case (state_q)
            S_WREN:  state_d = (kind_q == CMD_PROG) ? S_PLOAD : S_ERASE;
            S_PLOAD: state_d = S_PEXEC;
            S_PEXEC, S_ERASE, S_PREAD: state_d = S_POLL;
            S_POLL: begin
              if (st_busy) begin
                if (poll_last) begin
                  state_d  = S_DONE;
                  result_d = RES_TIMEOUT;
                end
              end else if (kind_q == CMD_READ) begin
                state_d = S_CREAD;
                ecc_d   = st_res;
              end else begin
                state_d  = S_DONE;
                result_d = st_res;
              end
            end
            S_CREAD: begin
              state_d  = S_DONE;
              result_d = ecc_q;
            end
            S_CFG: begin
              state_d  = S_DONE;
              result_d = RES_OK;
            end
            default: state_d = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      result_q <= RES_OK;
      ecc_q    <= RES_OK;
      kind_q   <= CMD_READ;
      row_q    <= '0;
      col_q    <= '0;
      len_q    <= '0;
      fast_q   <= 1'b0;
      keep_q   <= 1'b0;
      cfg_q    <= '0;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
      ecc_q    <= ecc_d;
      if (accept) begin
        kind_q <= cmd_e'(cmd_type_i);
        row_q  <= cmd_row_i;
        col_q  <= cmd_col_i;
        len_q  <= cmd_len_i;
        fast_q <= cmd_fast_i;
        keep_q <= cmd_keep_i;
        cfg_q  <= cmd_cfg_i;
      end
    end
  end

  assign busy_o           = (state_q != S_IDLE);
  assign done_o           = (state_q == S_DONE);
  assign result_o         = result_q;
  assign pe_req_o         = (state_q != S_IDLE) && (state_q != S_DONE);
  assign pe_opcode_o      = desc.opcode;
  assign pe_addr_o        = desc.addr;
  assign pe_addr_bytes_o  = desc.nab;
  assign pe_dummy_bytes_o = desc.ndum;
  assign pe_dir_o         = desc.dir;
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk #(
  parameter int POLL_MAX = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        pe_req_o,
  input logic [7:0]  pe_opcode_o,
  input logic [23:0] pe_addr_o,
  input logic        pe_done_i
);
  localparam int CW = $clog2(POLL_MAX + 2);
  logic [7:0]    last_op_q;
  logic [CW-1:0] polls_q;
  logic          start;

  assign start = !busy_o && cmd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_op_q <= 8'h00;
      polls_q   <= '0;
    end else if (start) begin
      last_op_q <= 8'h00;
      polls_q   <= '0;
    end else if (pe_req_o && pe_done_i) begin
      last_op_q <= pe_opcode_o;
      if (pe_opcode_o == 8'h0F) polls_q <= polls_q + 1'b1;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R11
  req_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pe_req_o |-> busy_o && !done_o);
  // R12
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_o && !pe_done_i |=> pe_req_o && $stable(pe_opcode_o) && $stable(pe_addr_o));
  // R4
  poll_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) polls_q <= CW'(POLL_MAX));
  // R7
  exec_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_o && pe_opcode_o == 8'h10 |-> last_op_q == 8'h02 || last_op_q == 8'h84);
  // R9
  erase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_o && pe_opcode_o == 8'hD8 |-> last_op_q == 8'h06);
  // R5
  cread_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_o && (pe_opcode_o == 8'h03 || pe_opcode_o == 8'h0B) |-> last_op_q == 8'h0F);
endmodule

bind nand_page_seq nand_page_seq_chk #(.POLL_MAX(POLL_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pe_req_o   (pe_req_o),
  .pe_opcode_o(pe_opcode_o),
  .pe_addr_o  (pe_addr_o),
  .pe_done_i  (pe_done_i)
);

// File: tb/nand_page_seq_test.sv
module nand_page_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;
  localparam int POLL_MAX = 4;
  localparam int LAT = 2;
  localparam int MAXOPS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = '0;
  logic [23:0] cmd_row = '0;
  logic [15:0] cmd_col = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic cmd_fast = 1'b0, cmd_keep = 1'b0;
  logic [1:0] cmd_cfg = '0;
  logic busy, done;
  logic [2:0] result;
  logic pe_req;
  logic [7:0] pe_opcode, pe_wdata;
  logic [23:0] pe_addr;
  logic [1:0] pe_nab, pe_ndum, pe_dir;
  logic [LEN_W-1:0] pe_len;
  logic pe_done = 1'b0;
  logic [7:0] pe_rdata = '0;

  int checks = 0, failures = 0;
  int n_ops = 0, poll_idx = 0, busy_reads = 0, hold_err = 0;
  logic [7:0] final_status = '0;
  logic [57:0] got_e [0:MAXOPS-1];
  logic [57:0] exp_e [0:MAXOPS-1];
  int n_exp = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_seq #(.LEN_W(LEN_W), .POLL_MAX(POLL_MAX), .CACHE_DUMMY(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_type_i(cmd_type),
    .cmd_row_i(cmd_row), .cmd_col_i(cmd_col), .cmd_len_i(cmd_len), .cmd_fast_i(cmd_fast),
    .cmd_keep_i(cmd_keep), .cmd_cfg_i(cmd_cfg), .busy_o(busy), .done_o(done), .result_o(result),
    .pe_req_o(pe_req), .pe_opcode_o(pe_opcode), .pe_addr_o(pe_addr), .pe_addr_bytes_o(pe_nab),
    .pe_dummy_bytes_o(pe_ndum), .pe_dir_o(pe_dir), .pe_len_o(pe_len), .pe_wdata_o(pe_wdata),
    .pe_done_i(pe_done), .pe_rdata_i(pe_rdata)
  );

  function automatic logic [57:0] pack_desc(logic [7:0] op, logic [23:0] ad, logic [1:0] nab,
      logic [1:0] nd, logic [1:0] dir, logic [LEN_W-1:0] ln, logic [7:0] wd);
    return {op, ad, nab, nd, dir, ln, wd};
  endfunction

  // phase engine model
  initial begin
    forever begin
      @(negedge clk);
      pe_done  = 1'b0;
      pe_rdata = '0;
      if (pe_req) begin
        logic [57:0] cap;
        cap = pack_desc(pe_opcode, pe_addr, pe_nab, pe_ndum, pe_dir, pe_len, pe_wdata);
        repeat (LAT - 1) @(negedge clk);
        if (!pe_req || cap != pack_desc(pe_opcode, pe_addr, pe_nab, pe_ndum, pe_dir, pe_len, pe_wdata))
          hold_err++;
        if (pe_opcode == 8'h0F) begin
          pe_rdata = (poll_idx < busy_reads) ? 8'h01 : final_status;
          poll_idx++;
        end
        if (n_ops < MAXOPS) got_e[n_ops] = cap;
        n_ops++;
        pe_done = 1'b1;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_exp(logic [57:0] e);
    exp_e[n_exp] = e;
    n_exp++;
  endtask

  task automatic run_cmd(int kind, logic [23:0] row, logic [15:0] col, logic [LEN_W-1:0] ln,
      bit fast, bit keep, logic [1:0] cfg, int breads, logic [7:0] fstat, bit inject, string req);
    int exp_res;
    int polls;
    bit tmo;
    int k;
    tmo   = (breads >= POLL_MAX);
    polls = tmo ? POLL_MAX : breads + 1;
    n_exp = 0;
    exp_res = 0;
    // expected operation list and result from the requirements
    if (kind == 1 || kind == 2) add_exp(pack_desc(8'h06, 0, 0, 0, 0, 0, 0));
    if (kind == 0) add_exp(pack_desc(8'h13, row, 3, 0, 0, 0, 0));
    if (kind == 1) begin
      add_exp(pack_desc(keep ? 8'h84 : 8'h02, {8'h0, col}, 2, 0, 2, ln, 0));
      add_exp(pack_desc(8'h10, row, 3, 0, 0, 0, 0));
    end
    if (kind == 2) add_exp(pack_desc(8'hD8, row, 3, 0, 0, 0, 0));
    if (kind == 3) add_exp(pack_desc(8'h1F, 24'hB0, 1, 0, 2, 1, {3'b0, cfg[1], 3'b0, cfg[0]}));
    else begin
      for (int p = 0; p < polls; p++) add_exp(pack_desc(8'h0F, 24'hC0, 1, 0, 1, 1, 0));
      if (kind == 0 && !tmo) add_exp(pack_desc(fast ? 8'h0B : 8'h03, {8'h0, col}, 2, 1, 1, ln, 0));
      if (tmo) exp_res = 5;
      else if (kind == 0) exp_res = (fstat[5:4] == 0) ? 0 : (fstat[5:4] == 1) ? 1 : 2;
      else if (kind == 1) exp_res = fstat[3] ? 3 : 0;
      else exp_res = fstat[2] ? 4 : 0;
    end

    @(negedge clk);
    n_ops = 0; poll_idx = 0; hold_err = 0;
    busy_reads = breads; final_status = fstat;
    cmd_type = 2'(kind); cmd_row = row; cmd_col = col; cmd_len = ln;
    cmd_fast = fast; cmd_keep = keep; cmd_cfg = cfg; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    k = 0;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
      if (inject && k == 3) begin cmd_valid = 1'b1; cmd_type = 2'd3; end
      if (inject && k == 4) begin cmd_valid = 1'b0; cmd_type = 2'(kind); end
    end
    check(done == 1'b1, {req, " done seen"}, done, 1);
    check(pe_req == 1'b0, "R11 no request in done cycle", pe_req, 0);
    check(result == 3'(exp_res), {req, " result"}, result, exp_res);
    check(n_ops == n_exp, {req, " op count"}, n_ops, n_exp);
    for (int i = 0; i < n_exp && i < n_ops; i++)
      check(got_e[i] == exp_e[i], {req, " op descriptor"}, int'(got_e[i][57:26]), int'(exp_e[i][57:26]));
    check(hold_err == 0, "R12 descriptor held until done", hold_err, 0);
    @(negedge clk);
    check(!done && !busy, "R11 done one cycle then idle", {done, busy}, 0);
    repeat (2) @(negedge clk);
    check(result == 3'(exp_res), "R11 result held", result, exp_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(!busy && !done && !pe_req && result == 0, "R1 reset state", {busy, done, pe_req, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !pe_req, "R1 idle after reset", {busy, pe_req}, 0);

    // R2 R3 R5 R6: reads over ECC field, both opcodes, busy lengths
    for (int ecc = 0; ecc < 4; ecc++)
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 3; b++) begin
          logic [7:0] st;
          st = {2'b00, 2'(ecc), 2'(b), 2'b00};
          run_cmd(0, 24'h010203 + 24'(ecc * 24'h111 + b), 16'(ecc * 37 + f * 5), LEN_W'(1 + ecc * 100 + b),
                  f[0], 1'b0, 2'b00, b, st, 1'b0, "R2 R3 R5 R6 read");
        end
    // R7 R8: program over keep and both fail flags
    for (int kp = 0; kp < 2; kp++)
      for (int fl = 0; fl < 4; fl++)
        run_cmd(1, 24'h00A000 + 24'(fl), 16'(kp * 300 + fl), LEN_W'(64 + fl), 1'b0, kp[0], 2'b00,
                fl % 3, {4'b0, 2'(fl), 2'b00}, 1'b0, "R7 R8 program");
    // R9: erase over both fail flags
    for (int fl = 0; fl < 4; fl++)
      run_cmd(2, 24'h3F0040 + 24'(fl * 64), 16'h0, LEN_W'(0), 1'b0, 1'b0, 2'b00,
              fl, {4'b0, 2'(fl), 2'b00}, 1'b0, "R9 erase");
    // R4: timeout edge, one below and at POLL_MAX
    run_cmd(0, 24'h000777, 16'h10, LEN_W'(8), 1'b1, 1'b0, 2'b00, POLL_MAX - 1, 8'h20, 1'b0, "R4 read below limit");
    run_cmd(0, 24'h000777, 16'h10, LEN_W'(8), 1'b1, 1'b0, 2'b00, POLL_MAX, 8'h20, 1'b0, "R4 read timeout");
    run_cmd(1, 24'h000888, 16'h20, LEN_W'(9), 1'b0, 1'b1, 2'b00, POLL_MAX + 3, 8'h08, 1'b0, "R4 program timeout");
    run_cmd(2, 24'h000999, 16'h0, LEN_W'(0), 1'b0, 1'b0, 2'b00, POLL_MAX, 8'h04, 1'b0, "R4 erase timeout");
    // R10: every configuration bit pair
    for (int c = 0; c < 4; c++)
      run_cmd(3, 24'h0, 16'h0, LEN_W'(0), 1'b0, 1'b0, 2'(c), 0, 8'h00, 1'b0, "R10 configuration");
    // R11: command ignored while busy
    run_cmd(1, 24'h012345, 16'h0444, LEN_W'(2048), 1'b0, 1'b0, 2'b00, 2, 8'h00, 1'b1, "R11 program with stray command");
    run_cmd(0, 24'h054321, 16'h0123, LEN_W'(16), 1'b0, 1'b0, 2'b00, 1, 8'h10, 1'b1, "R11 read with stray command");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule